// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block collects up to 32 interrupt request lines and merges them into one interrupt output. Each line passes through an input gate (mask) before it can set a sticky pending bit. The pending bit is set either on a rising edge of the line or in every cycle the line is high, chosen per channel. A separate output gate (enable) decides which pending bits drive the combined output. That output is either a level, high while any enabled bit is pending, or a one-cycle pulse each time a new enabled bit becomes pending.

Software reaches the control and status words through a small word-addressed port. A read returns its data one cycle after the request, and that data reflects every write issued in earlier cycles. Software can therefore confirm that a sequence of writes has landed by reading back any register. Pending bits are cleared by writing ones to the clear word. Several controllers can be cascaded by wiring one output into another's input line.

Top module: `irq_hub`

## Requirements
- R1: After reset every register reads 0, no channel is pending and `irq_out` is low.
- R2: The word addresses are 0 pending (read only), 1 input gate, 2 output gate, 3 trigger select, 4 clear (write only, reads 0), 5 output style. Addresses 6 and 7 read 0. Bits at or above NUM_CH read 0 and ignore writes.
- R3: A channel whose input-gate bit is 0 never becomes pending, whatever its input does.
- R4: With trigger-select bit 1, a channel becomes pending on a 0-to-1 transition of its input. An input held high does not set the bit again after it is cleared.
- R5: Writing 1 to a bit of the clear word clears that pending bit, and bits written 0 keep their state.
- R6: With trigger-select bit 0, a channel is set in every cycle its gated input is high, so clearing it while the input stays high leaves it pending.
- R7: A pending channel whose output-gate bit is 0 does not drive `irq_out`.
- R8: With output style 0, `irq_out` is high exactly while at least one channel is both pending and enabled.
- R9: With a nonzero output style, `irq_out` is high for one cycle in the cycle after a channel newly becomes pending and enabled, and low otherwise.
- R10: `host_rvalid` goes high in the cycle after a read request, and `host_rdata` then reflects every write made in earlier cycles, including the cycle just before the read.
- R11: When a set event and a clear of the same bit occur in the same cycle, the bit is left pending.
- R12: Several channels can be pending at once, and each appears at its own bit in the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_CH | Interrupt request lines, one per channel |
| host_req | input | 1 | Register access request |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 3 | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Combined interrupt, level or pulse |

## Verification
The bench builds the block with NUM_CH set to 8 and DATA_W left at 32, so the upper 24 bits of every word are unimplemented. Writing all ones and reading back checks that those bits stay 0. The eight channels still allow edge and level channels, masked and enabled channels, and several pending bits to be exercised side by side. A set and a clear of one bit are also driven in the same cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int HUB_ADDR_W = 3;

   typedef enum logic [HUB_ADDR_W-1:0] {
      HUB_PEND  = 3'd0,
      HUB_GATE  = 3'd1,
      HUB_OPEN  = 3'd2,
      HUB_TRIG  = 3'd3,
      HUB_CLR   = 3'd4,
      HUB_STYLE = 3'd5
   } hub_reg_e;

endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
   import irq_hub_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  wr,
   input  logic [HUB_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NUM_CH-1:0]     pend,
   output logic [NUM_CH-1:0]     gate,
   output logic [NUM_CH-1:0]     open_en,
   output logic [NUM_CH-1:0]     trig_edge,
   output logic [NUM_CH-1:0]     clr,
   output logic                  pulse_mode,
   output logic [DATA_W-1:0]     rdata,
   output logic                  rvalid
);

   logic [NUM_CH-1:0] style_q;
   logic [NUM_CH-1:0] wbits;
   logic              do_wr;
   logic              do_rd;
   logic [DATA_W-1:0] rd_mux;

   assign wbits = wdata[NUM_CH-1:0];
   assign do_wr = req && wr;
   assign do_rd = req && !wr;

   generate
      if (NUM_CH < DATA_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = |wdata[DATA_W-1:NUM_CH];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate      <= '0;
         open_en   <= '0;
         trig_edge <= '0;
         style_q   <= '0;
      end else if (do_wr) begin
         case (addr)
            HUB_GATE:  gate      <= wbits;
            HUB_OPEN:  open_en   <= wbits;
            HUB_TRIG:  trig_edge <= wbits;
            HUB_STYLE: style_q   <= wbits;
            default: ;
         endcase
      end
   end

   assign clr        = (do_wr && addr == HUB_CLR) ? wbits : '0;
   assign pulse_mode = |style_q;

   always_comb begin
      rd_mux = '0;
      case (addr)
         HUB_PEND:  rd_mux[NUM_CH-1:0] = pend;
         HUB_GATE:  rd_mux[NUM_CH-1:0] = gate;
         HUB_OPEN:  rd_mux[NUM_CH-1:0] = open_en;
         HUB_TRIG:  rd_mux[NUM_CH-1:0] = trig_edge;
         HUB_STYLE: rd_mux[NUM_CH-1:0] = style_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= do_rd;
         if (do_rd) rdata <= rd_mux;
      end
   end

   AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(req && !wr)); // R10

endmodule

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
   parameter int NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] irq_in,
   input  logic [NUM_CH-1:0] gate,
   input  logic [NUM_CH-1:0] trig_edge,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] pend
);

   logic [NUM_CH-1:0] evt;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic last_in;
      logic hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_in <= 1'b0;
         else        last_in <= irq_in[c];
      end

      assign hit    = trig_edge[c] ? (irq_in[c] && !last_in) : irq_in[c];
      assign evt[c] = gate[c] && hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend[c] <= 1'b0;
         else if (evt[c]) pend[c] <= 1'b1;
         else if (clr[c]) pend[c] <= 1'b0;
      end
   end

   AST_GATED_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(gate)) == '0)); // R3
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & $past(clr) & ~$past(evt)) == '0)); // R5
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & $past(evt)) == $past(evt))); // R11

endmodule

// File: rtl/irq_hub_out.sv
module irq_hub_out #(
   parameter int NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend,
   input  logic [NUM_CH-1:0] open_en,
   input  logic              pulse_mode,
   output logic              irq_out
);

   logic [NUM_CH-1:0] live;
   logic [NUM_CH-1:0] live_q;
   logic              fresh;

   assign live  = pend & open_en;
   assign fresh = |(live & ~live_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= live;
   end

   assign irq_out = pulse_mode ? fresh : (|live);

   AST_PULSE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode && $stable(pend) && $stable(open_en) && $past(pulse_mode)) |-> !irq_out); // R9

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CH-1:0]     irq_in,
   input  logic                  host_req,
   input  logic                  host_wr,
   input  logic [HUB_ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic [DATA_W-1:0]     host_rdata,
   output logic                  host_rvalid,
   output logic                  irq_out
);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 32 && NUM_CH <= DATA_W)
         else $error("irq_hub: NUM_CH must lie in 1..min(32,DATA_W)");
   end

   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] gate;
   logic [NUM_CH-1:0] open_en;
   logic [NUM_CH-1:0] trig_edge;
   logic [NUM_CH-1:0] clr;
   logic              pulse_mode;

   irq_hub_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req(host_req), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
      .pend(pend), .gate(gate), .open_en(open_en), .trig_edge(trig_edge),
      .clr(clr), .pulse_mode(pulse_mode),
      .rdata(host_rdata), .rvalid(host_rvalid)
   );

   irq_hub_capture #(.NUM_CH(NUM_CH)) u_cap (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .gate(gate), .trig_edge(trig_edge), .clr(clr), .pend(pend)
   );

   irq_hub_out #(.NUM_CH(NUM_CH)) u_out (
      .clk(clk), .rst_n(rst_n), .pend(pend), .open_en(open_en),
      .pulse_mode(pulse_mode), .irq_out(irq_out)
   );

   AST_CLOSED_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (open_en == '0) |-> !irq_out); // R7

endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DW  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] irq_in = '0;
   logic           host_req = 1'b0;
   logic           host_wr = 1'b0;
   logic [2:0]     host_addr = '0;
   logic [DW-1:0]  host_wdata = '0;
   logic [DW-1:0]  host_rdata;
   logic           host_rvalid;
   logic           irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_hub #(.NUM_CH(NCH), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .irq_out(irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      host_req = 1'b1; host_wr = 1'b0; host_addr = a;
      @(posedge clk); @(negedge clk);
      host_req = 1'b0;
      check("R10 rvalid", {31'd0, host_rvalid}, 32'd1);
      d = host_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic tidy();
      irq_in = '0;
      wr_reg(3'd1, 0); wr_reg(3'd2, 0); wr_reg(3'd3, 0); wr_reg(3'd5, 0);
      wr_reg(3'd4, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq_out", {31'd0, irq_out}, 0);
      for (int a = 0; a < 6; a++) begin
         rd_reg(a[2:0], d);
         check("R1 reg", d, 0);
      end
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr_reg(3'd1, 32'hFFFF_FFFF);
      rd_reg(3'd1, d); check("R2 upper bits", d, 32'h0000_00FF);
      wr_reg(3'd2, 32'h0000_00A5);
      rd_reg(3'd2, d); check("R10 readback after write", d, 32'hA5);
      wr_reg(3'd3, 32'h0000_005A);
      rd_reg(3'd3, d); check("R2 trig", d, 32'h5A);
      rd_reg(3'd4, d); check("R2 clear reads 0", d, 0);
      rd_reg(3'd7, d); check("R2 unmapped", d, 0);
      tidy();
   endtask

   task automatic t_gate();
      logic [31:0] d;
      irq_in[3] = 1'b1;
      tick(3);
      rd_reg(3'd0, d); check("R3 gated channel", d, 0);
      tidy();
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr_reg(3'd1, 32'h4);
      irq_in[2] = 1'b1;
      tick(1);
      rd_reg(3'd0, d); check("R6 level set", d, 32'h4);
      wr_reg(3'd4, 32'h4);
      rd_reg(3'd0, d); check("R6 clear while high", d, 32'h4);
      irq_in[2] = 1'b0;
      tick(1);
      wr_reg(3'd4, 32'h4);
      rd_reg(3'd0, d); check("R5 clear after drop", d, 0);
      tidy();
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr_reg(3'd3, 32'h10); wr_reg(3'd1, 32'h10);
      irq_in[4] = 1'b1;
      tick(1);
      rd_reg(3'd0, d); check("R4 edge set", d, 32'h10);
      wr_reg(3'd4, 32'h10);
      tick(2);
      rd_reg(3'd0, d); check("R4 held high no reset", d, 0);
      tidy();
   endtask

   task automatic t_multi();
      logic [31:0] d;
      wr_reg(3'd3, 32'h3); wr_reg(3'd1, 32'h3);
      irq_in[1:0] = 2'b11;
      tick(1);
      irq_in[1:0] = 2'b00;
      rd_reg(3'd0, d); check("R12 two pending", d, 32'h3);
      wr_reg(3'd4, 32'h1);
      rd_reg(3'd0, d); check("R5 selective clear", d, 32'h2);
      wr_reg(3'd4, 32'h2);
      rd_reg(3'd0, d); check("R5 second clear", d, 0);
      tidy();
   endtask

   task automatic t_setwins();
      logic [31:0] d;
      wr_reg(3'd3, 32'h20); wr_reg(3'd1, 32'h20);
      irq_in[5] = 1'b1;
      wr_reg(3'd4, 32'h20);
      rd_reg(3'd0, d); check("R11 set beats clear", d, 32'h20);
      tidy();
   endtask

   task automatic t_level_out();
      wr_reg(3'd3, 32'h40); wr_reg(3'd1, 32'h40);
      irq_in[6] = 1'b1; tick(1); irq_in[6] = 1'b0; tick(1);
      check("R7 disabled pending quiet", {31'd0, irq_out}, 0);
      wr_reg(3'd2, 32'h40);
      check("R8 level high", {31'd0, irq_out}, 1);
      tick(2);
      check("R8 level held", {31'd0, irq_out}, 1);
      wr_reg(3'd4, 32'h40);
      check("R8 level low after clear", {31'd0, irq_out}, 0);
      tidy();
   endtask

   task automatic t_pulse();
      wr_reg(3'd5, 32'h1); wr_reg(3'd3, 32'h3);
      wr_reg(3'd1, 32'h3); wr_reg(3'd2, 32'h3);
      check("R9 idle low", {31'd0, irq_out}, 0);
      irq_in[0] = 1'b1;
      tick(1);
      check("R9 first pulse", {31'd0, irq_out}, 1);
      tick(1);
      check("R9 pulse ends", {31'd0, irq_out}, 0);
      irq_in[1] = 1'b1;
      tick(1);
      check("R9 second pulse", {31'd0, irq_out}, 1);
      tick(1);
      check("R9 second ends", {31'd0, irq_out}, 0);
      tidy();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_gate();
      t_level();
      t_edge();
      t_multi();
      t_setwins();
      t_level_out();
      t_pulse();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule